// File: doc/BRIEF.md
# Processor-Side Interrupt Interface Bank

This block is the part of an interrupt controller that faces the processors. For each of up to `NCPU` processors it keeps a control word, a priority mask, a binary point value, a set of active-interrupt bits and a running priority. Software reaches all of it through one register port. The port carries a processor select, a word address, and separate read and write strobes.

A distributor model, outside this block, gives each processor its current best pending interrupt: a valid flag, a 10-bit ID, an 8-bit priority and a 3-bit source processor number. Every cycle, each slice decides whether to raise its processor's interrupt line.

Reading the acknowledge word hands the pending ID to software and marks that ID active. Writing the end-of-interrupt word clears the ID's active bit. The running priority always follows the most urgent active interrupt.

A slice counts as enabled only when one of its two group-enable bits is set. Any other nonzero control value leaves the slice disabled.

Top module: `cif_bank`

## Requirements
- R1: After synchronous reset, every slice reads back control 0, mask 0xFF, binary point `BPR_MIN` and running priority 0xFF; all interrupt lines and `rd_data` are 0.
- R2: The control word (offset 0) stores and reads back all 32 written bits. A slice is enabled only when bit 0 or bit 1 of it is 1, so a value of 0x8 (bit 3 only) leaves the slice disabled.
- R3: `irq[c]` is a register that is re-evaluated on every clock, including the clock after any register write. It is 1 exactly when all of the following held one cycle earlier: `dist_en` was 1, slice c was enabled, `hp_valid[c]` was 1, the pending priority was numerically below the mask, and the pending ID was not active on c.
- R4: The binary point (offset 2) keeps the low 3 bits of a write. A value below `BPR_MIN` is stored as `BPR_MIN`.
- R5: The priority mask (offset 1) keeps the low 8 bits of a write. A pending priority equal to the mask does not raise the line.
- R6: A read of the acknowledge word (offset 3) returns the pending ID in bits 9:0 and the source number in bits 12:10. This happens when `dist_en`, the slice enable and `hp_valid` are all 1. The read also marks that ID active and records its priority.
- R7: In every other case, an acknowledge read returns the spurious ID 1023 (0x3FF) and changes no active state.
- R8: The running priority (offset 5) is the lowest numeric priority among the active IDs, or 0xFF when none are active. It is updated one clock after its inputs change, and only while the slice is enabled; while the slice is disabled it holds its value.
- R9: A write to the end-of-interrupt word (offset 4) clears the active bit of the ID in bits 9:0. The running priority then follows R8.
- R10: `reg_cpu` picks the slice, and no other slice is touched. Read data appears on `rd_data` one clock after the read strobe. Offsets 4, 6 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dist_en | input | 1 | Distributor global enable |
| hp_valid | input | NCPU | Pending interrupt present, one bit per processor |
| hp_id | input | NCPU*10 | Pending interrupt ID per processor |
| hp_pri | input | NCPU*8 | Pending interrupt priority per processor |
| hp_src | input | NCPU*3 | Source processor number per processor |
| reg_cpu | input | $clog2(NCPU) | Processor select for the register port |
| reg_addr | input | 3 | Word offset |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq | output | NCPU | Interrupt line per processor |

## Verification
The bench's first target is the enable decode. Writing 0x8 or 0 to the control word must leave the line low. A design that treats any nonzero control word as enabled would raise it.

The bench also probes the mask boundary with equal values. A less-or-equal compare would raise the line there.

For acknowledge, the bench checks that the line drops while the same ID stays pending. A design that ignores active state would keep interrupting. The bench also checks that an acknowledge while disabled gives 1023 and does not mark the ID active.

Finally, the bench disables a slice, sends an end-of-interrupt, and checks that the running priority is frozen until the slice is enabled again. A design that recomputes it at all times would drop to 0xFF too early.

// File: rtl/cif_pkg.sv
package cif_pkg;
  localparam int ID_W  = 10;
  localparam int SRC_W = 3;
  localparam int PRI_W = 8;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

  typedef enum logic [2:0] {
    RA_CTRL   = 3'd0,
    RA_MASK   = 3'd1,
    RA_BPT    = 3'd2,
    RA_ACK    = 3'd3,
    RA_EOI    = 3'd4,
    RA_RUNPRI = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/cif_runpri.sv
module cif_runpri #(
  parameter int NUM_IRQ = 16
) (
  input  logic [NUM_IRQ-1:0]                     act,
  input  logic [NUM_IRQ-1:0][cif_pkg::PRI_W-1:0] pri,
  output logic [cif_pkg::PRI_W-1:0]              min_pri
);
  always_comb begin
    min_pri = '1;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (act[i] && (pri[i] < min_pri)) min_pri = pri[i];
    end
  end
endmodule

// File: rtl/cif_slice.sv
module cif_slice
  import cif_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int BPR_MIN = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dist_en,
  input  logic             sel,
  input  logic             we,
  input  logic             re,
  input  logic [2:0]       addr,
  input  logic [31:0]      wdata,
  input  logic             hp_valid,
  input  logic [ID_W-1:0]  hp_id,
  input  logic [PRI_W-1:0] hp_pri,
  input  logic [SRC_W-1:0] hp_src,
  output logic [31:0]      rd_word,
  output logic             irq
);
  localparam int IDX_W = $clog2(NUM_IRQ);
  localparam logic [ID_W-1:0] IRQ_LIM = ID_W'(NUM_IRQ);
  localparam logic [2:0] BPR_FLOOR = 3'(BPR_MIN);

  logic [31:0]      ctrl_q;
  logic [PRI_W-1:0] pmask_q;
  logic [2:0]       bpr_q;
  logic [NUM_IRQ-1:0] act_q;
  logic [NUM_IRQ-1:0][PRI_W-1:0] apri_q;
  logic [PRI_W-1:0] run_q;
  logic [PRI_W-1:0] min_w;
  logic             irq_q;

  logic en_w, pend_ok, hit_w, ack_take, eoi_hit;
  logic [IDX_W-1:0] hp_idx, eoi_idx;
  logic [31:0] ack_word;

  assign en_w    = ctrl_q[0] | ctrl_q[1];
  assign pend_ok = hp_valid & dist_en & en_w;
  assign hp_idx  = hp_id[IDX_W-1:0];
  assign eoi_idx = wdata[IDX_W-1:0];
  assign hit_w   = (hp_id < IRQ_LIM) && act_q[hp_idx];
  assign ack_take = sel && re && (addr == RA_ACK) && pend_ok && (hp_id < IRQ_LIM);
  assign eoi_hit  = sel && we && (addr == RA_EOI) && (wdata[ID_W-1:0] < IRQ_LIM);
  assign ack_word = pend_ok ? {{(32-SRC_W-ID_W){1'b0}}, hp_src, hp_id}
                            : {{(32-ID_W){1'b0}}, SPURIOUS_ID};

  cif_runpri #(.NUM_IRQ(NUM_IRQ)) u_min (
    .act(act_q), .pri(apri_q), .min_pri(min_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      pmask_q <= '1;
      bpr_q   <= BPR_FLOOR;
    end else if (sel && we) begin
      case (addr)
        RA_CTRL: ctrl_q  <= wdata;
        RA_MASK: pmask_q <= wdata[PRI_W-1:0];
        RA_BPT:  bpr_q   <= (wdata[2:0] < BPR_FLOOR) ? BPR_FLOOR : wdata[2:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
    end else begin
      if (eoi_hit) act_q[eoi_idx] <= 1'b0;
      if (ack_take) act_q[hp_idx] <= 1'b1;
    end
  end

  // priority store: one write port, indexed by ID
  always_ff @(posedge clk) begin
    if (ack_take) apri_q[hp_idx] <= hp_pri;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '1;
      irq_q <= 1'b0;
    end else begin
      if (en_w) run_q <= min_w;
      irq_q <= pend_ok && (hp_pri < pmask_q) && !hit_w;
    end
  end

  always_comb begin
    case (addr)
      RA_CTRL:   rd_word = ctrl_q;
      RA_MASK:   rd_word = {24'b0, pmask_q};
      RA_BPT:    rd_word = {29'b0, bpr_q};
      RA_ACK:    rd_word = ack_word;
      RA_RUNPRI: rd_word = {24'b0, run_q};
      default:   rd_word = '0;
    endcase
  end

  assign irq = irq_q;

  // R2 / R3: a disabled slice never drives its line
  a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    !$past(ctrl_q[0] | ctrl_q[1]) |-> !irq_q);
  // R5: pending priority at or above mask keeps the line low
  a_r5_mask_gate: assert property (@(posedge clk) disable iff (rst)
    $past(hp_pri >= pmask_q) |-> !irq_q);
  // R3: an already active ID does not re-signal
  a_r3_active_blocks: assert property (@(posedge clk) disable iff (rst)
    $past(hit_w) |-> !irq_q);
  // R8: enabled slice with nothing active settles to idle priority
  a_r8_idle_runpri: assert property (@(posedge clk) disable iff (rst)
    $past(en_w && (act_q == '0)) |-> (run_q == 8'hFF));
  // R4: binary point never below its floor
  a_r4_bpr_floor: assert property (@(posedge clk) disable iff (rst)
    bpr_q >= BPR_FLOOR);
endmodule

// File: rtl/cif_bank.sv
module cif_bank
  import cif_pkg::*;
#(
  parameter int NCPU    = 8,
  parameter int NUM_IRQ = 16,
  parameter int BPR_MIN = 2,
  localparam int CPU_W  = $clog2(NCPU)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   dist_en,
  input  logic [NCPU-1:0]        hp_valid,
  input  logic [NCPU*ID_W-1:0]   hp_id,
  input  logic [NCPU*PRI_W-1:0]  hp_pri,
  input  logic [NCPU*SRC_W-1:0]  hp_src,
  input  logic [CPU_W-1:0]       reg_cpu,
  input  logic [2:0]             reg_addr,
  input  logic                   reg_we,
  input  logic                   reg_re,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            rd_data,
  output logic [NCPU-1:0]        irq
);
  logic [31:0] words [NCPU];
  logic [31:0] rd_q;

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    cif_slice #(.NUM_IRQ(NUM_IRQ), .BPR_MIN(BPR_MIN)) u_slice (
      .clk     (clk),
      .rst     (rst),
      .dist_en (dist_en),
      .sel     (reg_cpu == CPU_W'(c)),
      .we      (reg_we),
      .re      (reg_re),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .hp_valid(hp_valid[c]),
      .hp_id   (hp_id[c*ID_W +: ID_W]),
      .hp_pri  (hp_pri[c*PRI_W +: PRI_W]),
      .hp_src  (hp_src[c*SRC_W +: SRC_W]),
      .rd_word (words[c]),
      .irq     (irq[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_q <= '0;
    else if (reg_re) rd_q <= words[reg_cpu];
  end

  assign rd_data = rd_q;

  // R10: read data changes only after a read strobe
  a_r10_read_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(reg_re) && !$past(rst) |-> $stable(rd_data));
endmodule

// File: tb/cif_bank_test.sv
module cif_bank_test;
  localparam int NCPU = 8;
  localparam int BPR_MIN = 2;

  logic clk = 0;
  logic rst = 1;
  logic dist_en = 1;
  logic [NCPU-1:0] hp_valid = '0;
  logic [NCPU*10-1:0] hp_id = '0;
  logic [NCPU*8-1:0] hp_pri = '0;
  logic [NCPU*3-1:0] hp_src = '0;
  logic [2:0] reg_cpu = '0;
  logic [2:0] reg_addr = '0;
  logic reg_we = 0, reg_re = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rd_data;
  logic [NCPU-1:0] irq;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cif_bank #(.NCPU(NCPU), .NUM_IRQ(16), .BPR_MIN(BPR_MIN)) uut (
    .clk, .rst, .dist_en, .hp_valid, .hp_id, .hp_pri, .hp_src,
    .reg_cpu, .reg_addr, .reg_we, .reg_re, .reg_wdata, .rd_data, .irq
  );

  // {dist_en, ctrl[3:0], mask[7:0], pri[7:0], expected irq}
  localparam logic [7:0][21:0] VEC = '{
    {1'b1, 4'h1, 8'h80, 8'h40, 1'b1},
    {1'b1, 4'h2, 8'h80, 8'h40, 1'b1},
    {1'b0, 4'h1, 8'h80, 8'h40, 1'b0},
    {1'b1, 4'h0, 8'h80, 8'h40, 1'b0},
    {1'b1, 4'h8, 8'h80, 8'h40, 1'b0},
    {1'b1, 4'h1, 8'h40, 8'h40, 1'b0},
    {1'b1, 4'h3, 8'h41, 8'h40, 1'b1},
    {1'b1, 4'h1, 8'h00, 8'h00, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int cpu, input int a, input logic [31:0] d);
    @(negedge clk);
    reg_cpu = 3'(cpu); reg_addr = 3'(a); reg_wdata = d; reg_we = 1;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input int cpu, input int a, output logic [31:0] d);
    @(negedge clk);
    reg_cpu = 3'(cpu); reg_addr = 3'(a); reg_re = 1;
    @(negedge clk);
    reg_re = 0;
    d = rd_data;
  endtask

  task automatic pend(input int cpu, input logic v, input int id, input int pri, input int src);
    hp_valid[cpu] = v;
    hp_id[cpu*10 +: 10] = 10'(id);
    hp_pri[cpu*8 +: 8] = 8'(pri);
    hp_src[cpu*3 +: 3] = 3'(src);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    check("R1 rd_data", rd_data, 0);
    rd(3, 0, d); check("R1 ctrl", d, 0);
    rd(3, 1, d); check("R1 mask", d, 32'hFF);
    rd(3, 2, d); check("R1 bpr", d, BPR_MIN);
    rd(3, 5, d); check("R1 runpri", d, 32'hFF);

    // R3 / R5 / R2 vector walk on slice 0
    for (int i = 0; i < 8; i++) begin
      logic [21:0] v;
      v = VEC[7-i];
      dist_en = v[21];
      pend(0, 1, 3, int'(v[8:1]), 0);
      wr(0, 0, {28'b0, v[20:17]});
      wr(0, 1, {24'b0, v[16:9]});
      repeat (2) @(negedge clk);
      check($sformatf("R3/R5 vec%0d irq", i), 32'(irq[0]), 32'(v[0]));
    end
    dist_en = 1;
    pend(0, 0, 0, 0, 0);

    // R2 full readback
    wr(1, 0, 32'hA5A5_0008);
    rd(1, 0, d); check("R2 ctrl readback", d, 32'hA5A5_0008);
    // R10 isolation
    rd(0, 0, d); check("R10 other slice untouched", d, 32'h1);
    rd(0, 4, d); check("R10 eoi reads zero", d, 0);
    rd(0, 6, d); check("R10 unmapped reads zero", d, 0);

    // R4 binary point
    wr(5, 2, 0); rd(5, 2, d); check("R4 floor clamp", d, BPR_MIN);
    wr(5, 2, 32'hFD); rd(5, 2, d); check("R4 low bits kept", d, 5);
    // R5 mask width
    wr(5, 1, 32'h1234); rd(5, 1, d); check("R5 mask low byte", d, 32'h34);

    // R7 disabled slice: spurious, no active marking
    pend(4, 1, 6, 8'h10, 1);
    wr(4, 0, 32'h8);
    rd(4, 3, d); check("R7 disabled ack spurious", d, 32'h3FF);
    wr(4, 0, 32'h1);
    repeat (2) @(negedge clk);
    check("R7 no active set while disabled", 32'(irq[4]), 1);
    pend(4, 0, 0, 0, 0);
    rd(4, 3, d); check("R7 nothing pending spurious", d, 32'h3FF);

    // R6 acknowledge and active blocking
    wr(2, 0, 32'h1);
    pend(2, 1, 5, 8'h40, 3);
    repeat (2) @(negedge clk);
    check("R3 line raised", 32'(irq[2]), 1);
    rd(2, 3, d); check("R6 ack word", d, 32'hC05);
    repeat (2) @(negedge clk);
    check("R6 line drops once active", 32'(irq[2]), 0);
    rd(2, 5, d); check("R8 runpri one active", d, 32'h40);
    pend(2, 1, 7, 8'h20, 0);
    repeat (2) @(negedge clk);
    check("R3 more urgent re-raises", 32'(irq[2]), 1);
    rd(2, 3, d); check("R6 second ack", d, 32'h007);
    rd(2, 5, d); check("R8 runpri min of two", d, 32'h20);
    pend(2, 0, 0, 0, 0);
    wr(2, 4, 7);
    rd(2, 5, d); check("R9 eoi recompute", d, 32'h40);

    // R8 hold while disabled, R9 eoi while disabled
    wr(2, 0, 32'h0);
    wr(2, 4, 5);
    repeat (2) @(negedge clk);
    rd(2, 5, d); check("R8 runpri frozen while disabled", d, 32'h40);
    wr(2, 0, 32'h2);
    repeat (2) @(negedge clk);
    rd(2, 5, d); check("R8 runpri idle after re-enable", d, 32'hFF);
    pend(2, 1, 5, 8'h40, 3);
    repeat (2) @(negedge clk);
    check("R9 cleared ID signals again", 32'(irq[2]), 1);

    summary();
  end
endmodule